// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked on-chip request port and an external asynchronous static RAM with a 17-bit byte address and an 8-bit data bus. A requester presents one read or one write at a time. The sequencer then drives the RAM's select pair, read strobe and write strobe through fixed phases. Each phase lasts a whole number of clock cycles, chosen so that the RAM's nanosecond minimums hold at the configured clock period and speed grade.

The RAM's data bus is split at the block edge into an outgoing value, a driver enable and an incoming value. The pad that joins them lies outside the block. Read data is captured into a holding register. Each completed access, read or write, is reported by a single-cycle acknowledge. After every access, one quiet cycle with the RAM deselected comes before the next request can be taken.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset the block is idle. `reqReady`=1, `ramSelN`=1, `ramSelP`=0, `ramRdEnN`=1, `ramWrEnN`=1, `ramDqOe`=0, `ackPulse`=0 and `rdData`=0.
- R2: The select pair is always driven in opposite polarity. The RAM is selected (`ramSelN`=0 with `ramSelP`=1) only during the access and recovery phases, and is deselected (`ramSelN`=1, `ramSelP`=0) at all other times.
- R3: A read holds the select pair active, `ramRdEnN`=0 and `ramWrEnN`=1 for exactly RD_CYC consecutive cycles, with `ramAddr` equal to the accepted address.
- R4: `rdData` takes the value on `ramDqIn` at the clock edge that ends the last read-access cycle. It holds that value until the next read completes, and writes leave it unchanged.
- R5: A write takes one setup cycle (selected, `ramWrEnN`=1), then exactly WP_CYC cycles with `ramWrEnN`=0, then one recovery cycle (selected, `ramWrEnN`=1). `ramRdEnN` stays 1 throughout.
- R6: `ramDqOe` is 1 only from the second cycle of `ramWrEnN`=0 through the recovery cycle, and is never 1 while `ramRdEnN`=0. While `ramDqOe` is 1, `ramDqOut` equals the accepted write data.
- R7: `ackPulse` is high for exactly one cycle after each access. It is the cycle after the last read-access cycle, or the cycle after the write recovery cycle.
- R8: `reqReady`=1 only when idle. A request is accepted at a rising edge where `reqValid` and `reqReady` are both 1. Later changes on `reqAddr`, `reqWdata` and `reqWrite` do not affect an access already in progress.
- R9: The cycle in which `ackPulse` is high has the RAM deselected, `ramRdEnN`=1, `ramWrEnN`=1, `ramDqOe`=0 and `reqReady`=0.
- R10: With clock period T ns, RD_CYC = ceil(tRC/T) and WP_CYC = max(ceil(tWP/T), ceil(tDW/T)+1, ceil(tWC/T)-2). For FAST_GRADE=1, tRC=tWC=12, tWP=tDW=8. For FAST_GRADE=0, tRC=tWC=15, tWP=tDW=10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request byte address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Idle, request can be taken |
| ackPulse | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Captured read data |
| ramAddr | output | ADDR_W | RAM address |
| ramSelN | output | 1 | Active-low RAM select |
| ramSelP | output | 1 | Active-high RAM select |
| ramRdEnN | output | 1 | Active-low RAM output enable |
| ramWrEnN | output | 1 | Active-low RAM write strobe |
| ramDqOut | output | DATA_W | Data toward the RAM |
| ramDqOe | output | 1 | Drive enable for ramDqOut |
| ramDqIn | input | DATA_W | Data from the RAM |

## Verification
Two events coincide in one cycle at the end of a write: the write strobe is released while the data driver is still on, so the data hold after the write's end is met. At the end of a read, the read-data capture and the acknowledge appear together. Both are provoked by long back-to-back streams of writes and reads, with the request inputs changed as soon as each request is accepted. A per-cycle reference model judges every pin. A behavioural RAM model commits each write on the strobe's rising edge and checks the pulse length, the data overlap and that no drive conflict occurs.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WSETUP, ST_WPULSE, ST_WRECOV, ST_GAP
  } ctrlState_e;

  // Strobes from the control FSM to the datapath and pins
  typedef struct packed {
    logic load;     // latch request fields
    logic selOn;    // RAM selected
    logic rdOn;     // RAM output enable active
    logic wrOn;     // RAM write strobe active
    logic drvOn;    // own data driver on
    logic capture;  // sample read data this edge
  } strobe_t;

  function automatic int unsigned cyclesFor(int unsigned ns, int unsigned clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned WP_CYC = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    ackPulse,
  output strobe_t strobe
);

  localparam int unsigned MAX_CYC = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  ctrlState_e state;
  logic [CNT_W-1:0] cnt;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE:   strobe.load = reqValid;
      ST_READ: begin
        strobe.selOn   = 1'b1;
        strobe.rdOn    = 1'b1;
        strobe.capture = (cnt == '0);
      end
      ST_WSETUP: strobe.selOn = 1'b1;
      ST_WPULSE: begin
        strobe.selOn = 1'b1;
        strobe.wrOn  = 1'b1;
        strobe.drvOn = (cnt != CNT_W'(WP_CYC - 1));
      end
      ST_WRECOV: begin
        strobe.selOn = 1'b1;
        strobe.drvOn = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ackPulse <= 1'b0;
    end else begin
      ackPulse <= 1'b0;
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state <= reqWrite ? ST_WSETUP : ST_READ;
          cnt   <= CNT_W'(RD_CYC - 1);
        end
        ST_READ: begin
          if (cnt == '0) begin
            state    <= ST_GAP;
            ackPulse <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        ST_WSETUP: begin
          state <= ST_WPULSE;
          cnt   <= CNT_W'(WP_CYC - 1);
        end
        ST_WPULSE: begin
          if (cnt == '0) state <= ST_WRECOV;
          else cnt <= cnt - 1'b1;
        end
        ST_WRECOV: begin
          state    <= ST_GAP;
          ackPulse <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Run-length counters used only by the phase-length assertions
  logic [CNT_W:0] rdRun, wrRun;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdRun <= '0;
      wrRun <= '0;
    end else begin
      rdRun <= strobe.rdOn ? rdRun + 1'b1 : '0;
      wrRun <= strobe.wrOn ? wrRun + 1'b1 : '0;
    end
  end

  a_r3_read_quiet_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdOn |-> (strobe.selOn && !strobe.wrOn && !strobe.drvOn));
  a_r5_write_selected: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrOn |-> (strobe.selOn && !strobe.rdOn));
  a_r6_driver_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drvOn |-> $past(strobe.wrOn));
  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> !ackPulse);
  a_r9_gap_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (!strobe.selOn && !strobe.rdOn && !strobe.wrOn && !reqReady));
  a_r10_read_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.rdOn) |-> (rdRun == (CNT_W+1)'(RD_CYC)));
  a_r10_pulse_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.wrOn) |-> (wrRun == (CNT_W+1)'(WP_CYC)));

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramDqIn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqOe,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdData <= '0;
    end else begin
      if (strobe.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.capture) rdData <= ramDqIn;
    end
  end

  assign ramAddr  = addrQ;
  assign ramDqOut = wdataQ;
  assign ramDqOe  = strobe.drvOn;

  a_r8_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selOn && $past(strobe.selOn)) |-> $stable(addrQ));
  a_r6_data_held: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drvOn && $past(strobe.drvOn)) |-> $stable(wdataQ));

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_NS     = 5,
  parameter bit          FAST_GRADE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              ackPulse,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramSelN,
  output logic              ramSelP,
  output logic              ramRdEnN,
  output logic              ramWrEnN,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqOe,
  input  logic [DATA_W-1:0] ramDqIn
);

  localparam int unsigned T_RC_NS = FAST_GRADE ? 12 : 15;
  localparam int unsigned T_WC_NS = FAST_GRADE ? 12 : 15;
  localparam int unsigned T_WP_NS = FAST_GRADE ? 8 : 10;
  localparam int unsigned T_DW_NS = FAST_GRADE ? 8 : 10;

  localparam int unsigned RD_CYC = cyclesFor(T_RC_NS, CLK_NS);
  localparam int unsigned WP_A   = cyclesFor(T_WP_NS, CLK_NS);
  localparam int unsigned WP_B   = cyclesFor(T_DW_NS, CLK_NS) + 1;
  localparam int unsigned WC_CYC = cyclesFor(T_WC_NS, CLK_NS);
  localparam int unsigned WP_C   = (WC_CYC > 2) ? WC_CYC - 2 : 1;
  localparam int unsigned WP_AB  = (WP_A > WP_B) ? WP_A : WP_B;
  localparam int unsigned WP_CYC = (WP_AB > WP_C) ? WP_AB : WP_C;

  strobe_t strobe;

  sram_ctrl_fsm #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC)) uFsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .ackPulse(ackPulse), .strobe(strobe)
  );

  sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .ramDqIn(ramDqIn), .ramAddr(ramAddr),
    .ramDqOut(ramDqOut), .ramDqOe(ramDqOe), .rdData(rdData)
  );

  assign ramSelN  = ~strobe.selOn;
  assign ramSelP  = strobe.selOn;
  assign ramRdEnN = ~strobe.rdOn;
  assign ramWrEnN = ~strobe.wrOn;

  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    ramDqOe |-> ramRdEnN);
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (ramSelN && !ramSelP && ramWrEnN && ramRdEnN && !ramDqOe));

endmodule

// File: tb/async_sram_ctrl_test.sv
`timescale 1ns/1ps
module async_sram_ctrl_test;

  localparam int CLK_NS = 4;
  localparam bit FAST   = 1'b0;
  localparam int AW     = 17;
  localparam int DW     = 8;

  // Bench-side timing numbers (R10)
  localparam int RC_NS = FAST ? 12 : 15;
  localparam int WC_NS = FAST ? 12 : 15;
  localparam int WP_NS = FAST ? 8 : 10;
  localparam int DW_NS = FAST ? 8 : 10;

  function automatic int ceilDiv(int a, int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  int rdExp, wpExp;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, ackPulse, ramSelN, ramSelP, ramRdEnN, ramWrEnN, ramDqOe;
  logic [DW-1:0] rdData, ramDqOut;
  logic [DW-1:0] ramDqIn = 8'hA5;
  logic [AW-1:0] ramAddr;

  always #(CLK_NS/2) clk = ~clk;

  async_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_NS), .FAST_GRADE(FAST)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .ackPulse(ackPulse), .rdData(rdData), .ramAddr(ramAddr),
    .ramSelN(ramSelN), .ramSelP(ramSelP), .ramRdEnN(ramRdEnN),
    .ramWrEnN(ramWrEnN), .ramDqOut(ramDqOut), .ramDqOe(ramDqOe),
    .ramDqIn(ramDqIn)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  function automatic logic [7:0] fillByte(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h5A;
  endfunction

  // ---------------- reference model ----------------
  typedef struct packed {
    bit ready; bit sel; bit rdN; bit wrN; bit drv; bit ack; bit gap;
    logic [AW-1:0] addr; logic [DW-1:0] dq; logic [DW-1:0] rd;
  } expVec_t;

  expVec_t expQ[$];
  expVec_t cur;
  logic [DW-1:0] refMem [int];
  logic [DW-1:0] lastRd = '0;

  function automatic expVec_t idleVec();
    expVec_t v;
    v = '0;
    v.ready = 1; v.rdN = 1; v.wrN = 1; v.rd = lastRd;
    return v;
  endfunction

  task automatic pushSchedule(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    expVec_t v;
    logic [DW-1:0] val;
    if (w) begin
      v = '0; v.sel = 1; v.rdN = 1; v.wrN = 1; v.addr = a; v.dq = d; v.rd = lastRd;
      expQ.push_back(v);
      for (int i = 0; i < wpExp; i++) begin
        v.wrN = 0; v.drv = (i > 0);
        expQ.push_back(v);
      end
      v.wrN = 1; v.drv = 1;
      expQ.push_back(v);
      v = '0; v.rdN = 1; v.wrN = 1; v.ack = 1; v.gap = 1; v.rd = lastRd;
      expQ.push_back(v);
      refMem[int'(a)] = d;
    end else begin
      val = refMem.exists(int'(a)) ? refMem[int'(a)] : fillByte(a);
      v = '0; v.sel = 1; v.rdN = 0; v.wrN = 1; v.addr = a; v.rd = lastRd;
      for (int i = 0; i < rdExp; i++) expQ.push_back(v);
      v = '0; v.rdN = 1; v.wrN = 1; v.ack = 1; v.gap = 1; v.rd = val;
      expQ.push_back(v);
      lastRd = val;
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      cur = idleVec();
    end else if (!finished) begin
      chk(reqReady == cur.ready, "R8", "reqReady", reqReady, cur.ready);
      chk(ramSelN == !cur.sel, cur.gap ? "R9" : "R2", "ramSelN", ramSelN, !cur.sel);
      chk(ramSelP == cur.sel, cur.gap ? "R9" : "R2", "ramSelP", ramSelP, cur.sel);
      chk(ramRdEnN == cur.rdN, cur.gap ? "R9" : "R3", "ramRdEnN", ramRdEnN, cur.rdN);
      chk(ramWrEnN == cur.wrN, cur.gap ? "R9" : "R5", "ramWrEnN", ramWrEnN, cur.wrN);
      chk(ramDqOe == cur.drv, "R6", "ramDqOe", ramDqOe, cur.drv);
      chk(ackPulse == cur.ack, "R7", "ackPulse", ackPulse, cur.ack);
      chk(rdData == cur.rd, "R4", "rdData", rdData, cur.rd);
      if (cur.sel) chk(ramAddr == cur.addr, "R3", "ramAddr", ramAddr, cur.addr);
      if (cur.drv) chk(ramDqOut == cur.dq, "R6", "ramDqOut", ramDqOut, cur.dq);
      if (cur.ready && reqValid) pushSchedule(reqWrite, reqAddr, reqWdata);
      cur = (expQ.size() != 0) ? expQ.pop_front() : idleVec();
    end
  end

  // ---------------- behavioural RAM with timing checks ----------------
  logic [DW-1:0] ramMem [int];
  int wrLow = 0, drvLow = 0, rdLow = 0;
  logic [AW-1:0] wAddr;
  logic [DW-1:0] wData;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (!ramSelN && ramSelP && !ramRdEnN && ramWrEnN)
        ramDqIn <= ramMem.exists(int'(ramAddr)) ? ramMem[int'(ramAddr)] : fillByte(ramAddr);
      else
        ramDqIn <= 8'hA5;
      if (ramDqOe && !ramRdEnN) chk(1'b0, "R6", "bus conflict", 1, 0);
      if (!ramWrEnN) begin
        wrLow++;
        wAddr = ramAddr;
        if (ramDqOe) begin drvLow++; wData = ramDqOut; end
      end else if (wrLow > 0) begin
        chk(wrLow * CLK_NS >= WP_NS, "R10", "write pulse ns", wrLow * CLK_NS, WP_NS);
        chk(drvLow * CLK_NS >= DW_NS, "R10", "data overlap ns", drvLow * CLK_NS, DW_NS);
        chk(ramDqOe == 1'b1, "R6", "data hold after strobe", ramDqOe, 1);
        ramMem[int'(wAddr)] = wData;
        wrLow = 0; drvLow = 0;
      end
      if (!ramRdEnN) rdLow++;
      else if (rdLow > 0) begin
        chk(rdLow * CLK_NS >= RC_NS, "R10", "read access ns", rdLow * CLK_NS, RC_NS);
        rdLow = 0;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(bit w, logic [AW-1:0] a, logic [DW-1:0] d, bit keep);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #1;
    if (!keep) begin
      // R8: changes after acceptance must not reach the RAM
      reqValid = 1'b0; reqWrite = ~w; reqAddr = 17'h0AAAA; reqWdata = 8'h99;
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * CLK_NS);
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    rdExp = ceilDiv(RC_NS, CLK_NS);
    wpExp = max3(ceilDiv(WP_NS, CLK_NS), ceilDiv(DW_NS, CLK_NS) + 1, ceilDiv(WC_NS, CLK_NS) - 2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1, "R1", "reqReady", reqReady, 1);
    chk(ramSelN == 1 && ramSelP == 0, "R1", "select pair", {ramSelN, ramSelP}, 2'b10);
    chk(ramRdEnN == 1 && ramWrEnN == 1, "R1", "strobes", {ramRdEnN, ramWrEnN}, 2'b11);
    chk(ramDqOe == 0, "R1", "ramDqOe", ramDqOe, 0);
    chk(ackPulse == 0, "R1", "ackPulse", ackPulse, 0);
    chk(rdData == 0, "R1", "rdData", rdData, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    repeat (2) @(posedge clk); #1;

    issue(1, 17'h00010, 8'h3C, 0);
    repeat (3) @(posedge clk); #1;
    issue(0, 17'h00010, 8'h00, 0);
    repeat (2) @(posedge clk); #1;
    // back-to-back, corner addresses and data
    issue(1, 17'h00000, 8'h00, 1);
    issue(1, 17'h1FFFF, 8'hFF, 1);
    issue(0, 17'h1FFFF, 8'h00, 1);
    issue(0, 17'h00000, 8'h00, 1);
    issue(0, 17'h0ABCD, 8'h00, 0);
    issue(1, 17'h00010, 8'hC3, 1);
    issue(0, 17'h00010, 8'h00, 0);
    for (int i = 0; i < 8; i++) issue(1, AW'(i * 4099 + 7), DW'(i * 37 + 1), 1);
    for (int i = 7; i >= 0; i--) issue(0, AW'(i * 4099 + 7), 8'h00, (i != 0));
    issue(1, 17'h00123, 8'h5A, 0);
    issue(0, 17'h1FFFF, 8'h00, 0);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(expQ.size() == 0, "R7", "schedule drained", expQ.size(), 0);
    finish();
  end

endmodule